// File: doc/BRIEF.md
# Multisampled Tile Offset Generator

This block turns an integer texel position (x, y) and a sample number into the byte offset of that sample inside a multisampled surface. The surface is cut into square tiles. Inside a tile, pixels are gathered into 2x2 quads, and every sample of a quad is stored together. The offset is therefore a sum of several fields: a tile term, a quad term, and a low field that packs the sample number with the position of the pixel inside its quad. It is not a plain row-major address.

The surface width in pixels is loaded through a configuration strobe. The block rounds the width up to whole tiles and stores the tile count per row. Requests enter through a valid/ready handshake and pass through three register stages: field split, constant scaling, and final sum. The pipeline accepts one request per clock. When the consumer holds off, every stage freezes. Each result carries an error flag for a sample number or x position that falls outside the surface. The offset is still formed from the masked fields.

Top module: `ms_tile_offset`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The tile term equals (x>>5)·16384 + (y>>5)·tiles_per_row·16384, using 32x32 tiles, 4 samples and 4-byte words. It is reduced modulo 2^32.
- R3: A configuration strobe loads tiles_per_row = ceil(cfg_width/32). The padded width is tiles_per_row·32.
- R4: The quad term equals (x AND 30)·32 + (y AND 30)·512.
- R5: Offset bit 2 equals x bit 0, and offset bit 3 equals y bit 0.
- R6: The low field is (sample AND 3) shifted left by 4, ORed with the pixel bits of R5. This field is added to the tile and quad terms, so offset bits 5:4 hold the masked sample number.
- R7: Every offset is a multiple of 4, so bits 1:0 are zero.
- R8: With out_ready held at 1, in_ready stays 1 and a request accepted at one clock edge shows as out_valid exactly three edges later. This gives one result per clock.
- R9: While out_valid is 1 and out_ready is 0, out_offset and out_err hold their values and no result is lost, duplicated or reordered.
- R10: A sample number of 4 or more sets out_err. The offset uses the sample number AND 3.
- R11: An x position at or beyond the padded width sets out_err. An x position of padded width − 1 does not.
- R12: A request uses the tiles_per_row value in force at the edge that accepts it. A strobe at that same edge or later does not change that request's offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strobe | input | 1 | Loads cfg_width on this edge |
| cfg_width | input | 16 | Surface width in pixels |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when in_valid is 1 |
| in_x | input | 16 | Texel column |
| in_y | input | 16 | Texel row |
| in_sample | input | 3 | Sample number |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_offset | output | 32 | Byte offset in the surface |
| out_err | output | 1 | Sample number or x position out of range |

## Verification
Single-bit x and y positions isolate the pixel bits, and even positions below 32 isolate the quad term. Positions of 32 and above isolate the tile term, and the row case also separates a correct tiles-per-row value from a wrong one. Sample numbers 1 to 3 on odd positions show whether the sample field is ORed at bit 4 or added in the wrong place. Numbers 4 to 7 and x positions on either side of the padded edge tell masking apart from the error flag. A strobe placed in the same cycle as a request shows whether the width is bound at acceptance. A long run of random positions under a random out_ready pattern exposes lost, repeated or corrupted results during stalls.

// File: rtl/msoff_pkg.sv
package msoff_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/msoff_cfg.sv
module msoff_cfg #(
   parameter int WIDTH_W = 16,
   parameter int TILE_SH = 5,
   parameter int TPR_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe,
   input  logic [WIDTH_W-1:0] width,
   output logic [TPR_W-1:0]   tpr,
   output logic [WIDTH_W:0]   pad_w
);
   localparam int SUM_W = WIDTH_W + 1;

   logic [SUM_W-1:0] rounded;
   logic [TPR_W-1:0] tpr_d;

   assign rounded = {1'b0, width} + SUM_W'((1 << TILE_SH) - 1);
   assign tpr_d   = TPR_W'(rounded >> TILE_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tpr <= '0;
      else if (strobe) tpr <= tpr_d;
   end

   assign pad_w = SUM_W'({tpr, {TILE_SH{1'b0}}});

   // R3
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(tpr));

endmodule

// File: rtl/msoff_extract.sv
module msoff_extract #(
   parameter int XY_W    = 16,
   parameter int TILE_SH = 5,
   parameter int SIDX_W  = 3,
   parameter int SMP_SH  = 2,
   parameter int WORD_SH = 2,
   parameter int TPR_W   = 12,
   parameter int PAD_W   = 17,
   parameter int CW      = XY_W - TILE_SH,
   parameter int LOW_W   = WORD_SH + 2 + SMP_SH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               v_in,
   input  logic [XY_W-1:0]    x,
   input  logic [XY_W-1:0]    y,
   input  logic [SIDX_W-1:0]  sample,
   input  logic [TPR_W-1:0]   tpr_in,
   input  logic [PAD_W-1:0]   pad_w,
   output logic               v_q,
   output logic [CW-1:0]      tcol_q,
   output logic [CW-1:0]      trow_q,
   output logic [TILE_SH-1:0] xg_q,
   output logic [TILE_SH-1:0] yg_q,
   output logic [LOW_W-1:0]   low_q,
   output logic               err_q,
   output logic [TPR_W-1:0]   tpr_q
);
   import msoff_pkg::*;

   localparam int SMP_BIT = WORD_SH + 2;
   localparam int CMP_W   = max_of(XY_W, PAD_W) + 1;

   logic [LOW_W-1:0]   smp_lo;
   logic               smp_err;
   logic               x_err;
   logic [LOW_W-1:0]   low_d;
   logic [TILE_SH-1:0] quad_mask;

   generate
      if (SMP_SH == 0) begin : g_single
         assign smp_lo  = '0;
         assign smp_err = |sample;
      end else if (SIDX_W > SMP_SH) begin : g_wide
         assign smp_lo  = LOW_W'(sample[SMP_SH-1:0]);
         assign smp_err = |sample[SIDX_W-1:SMP_SH];
      end else begin : g_exact
         assign smp_lo  = LOW_W'(sample);
         assign smp_err = 1'b0;
      end
   endgenerate

   assign x_err     = CMP_W'(x) >= CMP_W'(pad_w);
   assign quad_mask = ~TILE_SH'(1);
   assign low_d     = (smp_lo << SMP_BIT)
                    | (LOW_W'(y[0]) << (WORD_SH + 1))
                    | (LOW_W'(x[0]) << WORD_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         tcol_q <= '0;
         trow_q <= '0;
         xg_q   <= '0;
         yg_q   <= '0;
         low_q  <= '0;
         err_q  <= 1'b0;
         tpr_q  <= '0;
      end else if (en) begin
         v_q    <= v_in;
         tcol_q <= x[XY_W-1:TILE_SH];
         trow_q <= y[XY_W-1:TILE_SH];
         xg_q   <= x[TILE_SH-1:0] & quad_mask;
         yg_q   <= y[TILE_SH-1:0] & quad_mask;
         low_q  <= low_d;
         err_q  <= smp_err | x_err;
         tpr_q  <= tpr_in;
      end
   end

endmodule

// File: rtl/msoff_scale.sv
module msoff_scale #(
   parameter int CW         = 11,
   parameter int TILE_SH    = 5,
   parameter int LOW_W      = 6,
   parameter int TPR_W      = 12,
   parameter int ADDR_W     = 32,
   parameter int TILE_BYTES = 16384,
   parameter int GX_BYTES   = 32,
   parameter int GY_BYTES   = 512
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               v_in,
   input  logic [CW-1:0]      tcol,
   input  logic [CW-1:0]      trow,
   input  logic [TILE_SH-1:0] xg,
   input  logic [TILE_SH-1:0] yg,
   input  logic [LOW_W-1:0]   low_in,
   input  logic               err_in,
   input  logic [TPR_W-1:0]   tpr,
   output logic               v_q,
   output logic [ADDR_W-1:0]  tile_q,
   output logic [ADDR_W-1:0]  grp_q,
   output logic [LOW_W-1:0]   low_q,
   output logic               err_q
);
   logic [ADDR_W-1:0] col_term, row_term, tile_d, grp_d;

   assign col_term = ADDR_W'(tcol) * ADDR_W'(TILE_BYTES);
   assign row_term = ADDR_W'(trow) * ADDR_W'(tpr) * ADDR_W'(TILE_BYTES);
   assign tile_d   = col_term + row_term;
   assign grp_d    = ADDR_W'(xg) * ADDR_W'(GX_BYTES)
                   + ADDR_W'(yg) * ADDR_W'(GY_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         tile_q <= '0;
         grp_q  <= '0;
         low_q  <= '0;
         err_q  <= 1'b0;
      end else if (en) begin
         v_q    <= v_in;
         tile_q <= tile_d;
         grp_q  <= grp_d;
         low_q  <= low_in;
         err_q  <= err_in;
      end
   end

endmodule

// File: rtl/msoff_sum.sv
module msoff_sum #(
   parameter int ADDR_W  = 32,
   parameter int LOW_W   = 6,
   parameter int WORD_SH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              v_in,
   input  logic [ADDR_W-1:0] tile,
   input  logic [ADDR_W-1:0] grp,
   input  logic [LOW_W-1:0]  low_in,
   input  logic              err_in,
   output logic              v_q,
   output logic [ADDR_W-1:0] off_q,
   output logic              err_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         off_q <= '0;
         err_q <= 1'b0;
      end else if (en) begin
         v_q   <= v_in;
         off_q <= tile + grp + ADDR_W'(low_in);
         err_q <= err_in;
      end
   end

   // R5 R6
   low_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && v_in) |=> (off_q[LOW_W-1:0] == $past(low_in)));

   // R7
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |-> (off_q[WORD_SH-1:0] == '0));

endmodule

// File: rtl/ms_tile_offset.sv
module ms_tile_offset #(
   parameter int XY_W       = 16,
   parameter int ADDR_W     = 32,
   parameter int WIDTH_W    = 16,
   parameter int TILE_W     = 32,
   parameter int SAMPLES    = 4,
   parameter int WORD_BYTES = 4,
   parameter int SIDX_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_strobe,
   input  logic [WIDTH_W-1:0] cfg_width,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [XY_W-1:0]   in_x,
   input  logic [XY_W-1:0]   in_y,
   input  logic [SIDX_W-1:0] in_sample,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_offset,
   output logic              out_err
);
   import msoff_pkg::*;

   localparam int TILE_SH    = $clog2(TILE_W);
   localparam int SMP_SH     = $clog2(SAMPLES);
   localparam int WORD_SH    = $clog2(WORD_BYTES);
   localparam int CW         = XY_W - TILE_SH;
   localparam int TPR_W      = WIDTH_W + 1 - TILE_SH;
   localparam int PAD_W      = WIDTH_W + 1;
   localparam int LOW_W      = WORD_SH + 2 + SMP_SH;
   localparam int TILE_BYTES = TILE_W * TILE_W * SAMPLES * WORD_BYTES;
   localparam int GX_BYTES   = 2 * SAMPLES * WORD_BYTES;
   localparam int GY_BYTES   = TILE_W * SAMPLES * WORD_BYTES;

   generate
      if (!is_pow2(TILE_W) || TILE_W < 4) begin : g_bad_tile
         $error("TILE_W must be a power of two of at least 4");
      end
      if (!is_pow2(SAMPLES)) begin : g_bad_smp
         $error("SAMPLES must be a power of two");
      end
      if (!is_pow2(WORD_BYTES) || WORD_BYTES < 2) begin : g_bad_word
         $error("WORD_BYTES must be a power of two of at least 2");
      end
      if (SIDX_W < 1 || SIDX_W < SMP_SH) begin : g_bad_sidx
         $error("SIDX_W too narrow for SAMPLES");
      end
      if (XY_W <= TILE_SH || WIDTH_W <= TILE_SH) begin : g_bad_xy
         $error("coordinate or width field narrower than a tile");
      end
      if (ADDR_W < LOW_W + TILE_SH) begin : g_bad_addr
         $error("ADDR_W too narrow");
      end
   endgenerate

   logic adv;
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   logic [TPR_W-1:0] tpr_cur;
   logic [PAD_W-1:0] pad_cur;

   msoff_cfg #(.WIDTH_W(WIDTH_W), .TILE_SH(TILE_SH), .TPR_W(TPR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .strobe(cfg_strobe), .width(cfg_width),
      .tpr(tpr_cur), .pad_w(pad_cur));

   logic               s1_v, s1_err;
   logic [CW-1:0]      s1_tcol, s1_trow;
   logic [TILE_SH-1:0] s1_xg, s1_yg;
   logic [LOW_W-1:0]   s1_low;
   logic [TPR_W-1:0]   s1_tpr;

   msoff_extract #(
      .XY_W(XY_W), .TILE_SH(TILE_SH), .SIDX_W(SIDX_W), .SMP_SH(SMP_SH),
      .WORD_SH(WORD_SH), .TPR_W(TPR_W), .PAD_W(PAD_W), .CW(CW), .LOW_W(LOW_W)
   ) u_ext (
      .clk(clk), .rst_n(rst_n), .en(adv), .v_in(in_valid),
      .x(in_x), .y(in_y), .sample(in_sample), .tpr_in(tpr_cur), .pad_w(pad_cur),
      .v_q(s1_v), .tcol_q(s1_tcol), .trow_q(s1_trow), .xg_q(s1_xg),
      .yg_q(s1_yg), .low_q(s1_low), .err_q(s1_err), .tpr_q(s1_tpr));

   logic              s2_v, s2_err;
   logic [ADDR_W-1:0] s2_tile, s2_grp;
   logic [LOW_W-1:0]  s2_low;

   msoff_scale #(
      .CW(CW), .TILE_SH(TILE_SH), .LOW_W(LOW_W), .TPR_W(TPR_W), .ADDR_W(ADDR_W),
      .TILE_BYTES(TILE_BYTES), .GX_BYTES(GX_BYTES), .GY_BYTES(GY_BYTES)
   ) u_scl (
      .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s1_v),
      .tcol(s1_tcol), .trow(s1_trow), .xg(s1_xg), .yg(s1_yg),
      .low_in(s1_low), .err_in(s1_err), .tpr(s1_tpr),
      .v_q(s2_v), .tile_q(s2_tile), .grp_q(s2_grp), .low_q(s2_low), .err_q(s2_err));

   msoff_sum #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .WORD_SH(WORD_SH)) u_sum (
      .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s2_v),
      .tile(s2_tile), .grp(s2_grp), .low_in(s2_low), .err_in(s2_err),
      .v_q(out_valid), .off_q(out_offset), .err_q(out_err));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_offset) && $stable(out_err)));

endmodule

// File: tb/sim_ms_tile_offset.sv
`timescale 1ns/1ps
module sim_ms_tile_offset;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_strobe = 1'b0;
   logic [15:0] cfg_width = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_x = '0, in_y = '0;
   logic [2:0]  in_sample = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_offset;
   logic        out_err;

   always #2 clk = ~clk;

   ms_tile_offset u0 (
      .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .cfg_width(cfg_width),
      .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
      .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
      .out_offset(out_offset), .out_err(out_err));

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   int model_tpr = 0;
   bit lat_mode = 1'b1;
   bit ready_rand = 1'b0;
   bit finished = 1'b0;

   logic [31:0] q_off[$];
   logic        q_err[$];
   int          q_cyc[$];
   bit          q_lat[$];
   string       q_tag[$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic void model(input int x, input int y, input int s, input int tpr,
                                 output logic [31:0] off, output logic err);
      longint t;
      t = (longint'(x) / 32) * 16384 + (longint'(y) / 32) * longint'(tpr) * 16384
        + longint'(x & 30) * 32 + longint'(y & 30) * 512
        + longint'(((s & 3) * 16) | ((y & 1) * 8) | ((x & 1) * 4));
      off = t[31:0];
      err = (s >= 4) || (x >= tpr * 32);
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic send(input int x, input int y, input int s, input string tag,
                       input bit cfg_en = 1'b0, input int cfg_w = 0);
      bit done = 1'b0;
      bit first = 1'b1;
      logic [31:0] eo;
      logic ee;
      while (!done) begin
         @(negedge clk);
         in_valid   = 1'b1;
         in_x       = 16'(x);
         in_y       = 16'(y);
         in_sample  = 3'(s);
         cfg_strobe = first && cfg_en;
         cfg_width  = 16'(cfg_w);
         #1;
         if (lat_mode) check(in_ready == 1'b1, "R8 in_ready", longint'(in_ready), 1);
         if (in_ready) begin
            model(x, y, s, model_tpr, eo, ee);
            q_off.push_back(eo);
            q_err.push_back(ee);
            q_cyc.push_back(cyc);
            q_lat.push_back(lat_mode);
            q_tag.push_back(tag);
            done = 1'b1;
         end
         if (first && cfg_en) model_tpr = (cfg_w + 31) / 32;
         first = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid   = 1'b0;
         cfg_strobe = 1'b0;
      end
   endtask

   task automatic configure(input int w);
      @(negedge clk);
      in_valid   = 1'b0;
      cfg_strobe = 1'b1;
      cfg_width  = 16'(w);
      #1;
      model_tpr = (w + 31) / 32;
      @(negedge clk);
      cfg_strobe = 1'b0;
   endtask

   // monitor: owns out_ready, pops the scoreboard
   initial begin : monitor
      bit held = 1'b0;
      logic [31:0] h_off;
      logic h_err;
      forever begin
         @(negedge clk);
         out_ready = ready_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
         #1;
         if (held) begin
            check(out_valid && out_offset == h_off && out_err == h_err,
                  "R9 stall hold", longint'(out_offset), longint'(h_off));
            held = 1'b0;
         end
         if (out_valid && out_ready) begin
            if (q_off.size() == 0) begin
               check(1'b0, "R9 unexpected result", longint'(out_offset), 0);
            end else begin
               logic [31:0] eo;
               logic ee;
               int c0;
               bit lm;
               string tg;
               eo = q_off.pop_front();
               ee = q_err.pop_front();
               c0 = q_cyc.pop_front();
               lm = q_lat.pop_front();
               tg = q_tag.pop_front();
               check(out_offset == eo, {tg, " offset"}, longint'(out_offset), longint'(eo));
               check(out_err == ee, {tg, " err"}, longint'(out_err), longint'(ee));
               check(out_offset[1:0] == 2'b00, "R7 alignment", longint'(out_offset[1:0]), 0);
               if (lm) check(cyc - c0 == 3, "R8 latency", longint'(cyc - c0), 3);
            end
         end else if (out_valid && !out_ready) begin
            held  = 1'b1;
            h_off = out_offset;
            h_err = out_err;
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
      check(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);

      // R3: width 100 pads to 128, 4 tiles per row
      configure(100);
      send(0, 0, 0, "R4");
      send(2, 0, 0, "R4");
      send(0, 2, 0, "R4");
      send(30, 30, 0, "R4");
      send(1, 0, 0, "R5");
      send(0, 1, 0, "R5");
      send(1, 1, 0, "R5");
      send(31, 31, 0, "R5");
      send(1, 1, 1, "R6");
      send(0, 1, 2, "R6");
      send(1, 1, 3, "R6");
      send(32, 0, 0, "R2");
      send(0, 32, 0, "R3");
      send(96, 96, 2, "R2");
      send(127, 5, 0, "R11");
      send(128, 5, 0, "R11");
      send(3, 2, 4, "R10");
      send(3, 2, 5, "R10");
      send(1, 1, 7, "R10");
      idle(5);
      configure(96);
      send(0, 32, 0, "R3");
      send(95, 0, 0, "R11");
      send(96, 0, 0, "R11");
      configure(97);
      send(0, 64, 1, "R3");
      send(96, 0, 0, "R11");
      configure(1);
      send(0, 32, 0, "R3");
      send(31, 0, 0, "R11");
      send(32, 0, 0, "R11");
      // R12: strobe in the accepting cycle of the second request
      send(5, 40, 1, "R12");
      send(6, 40, 2, "R12", 1'b1, 2000);
      send(7, 40, 3, "R12");
      send(65535, 65535, 3, "R2");
      idle(6);

      // R9: random traffic under random back-pressure
      configure(60000);
      lat_mode   = 1'b0;
      ready_rand = 1'b1;
      for (int i = 0; i < 300; i++) begin
         if (i == 150) send(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                            int'($urandom_range(0, 7)), "R12", 1'b1, int'($urandom_range(1, 65535)));
         else send(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                   int'($urandom_range(0, 7)), "R9");
      end
      idle(1);
      for (int i = 0; i < 200 && q_off.size() != 0; i++) @(negedge clk);
      ready_rand = 1'b0;
      idle(4);
      check(q_off.size() == 0, "R9 drained", longint'(q_off.size()), 0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule